// File: doc/BRIEF.md
# Fourth-Order Low-Pass Biquad Cascade

This block smooths a stream of signed samples with a fixed-point fourth-order Butterworth low-pass response. It is built from two second-order recursive sections in series. A sample enters on any clock where the input strobe is high, so the sample rate is set by the frame timing around the block. Each accepted sample produces exactly one output sample with its own strobe, at a fixed latency. Both sections use the feed-forward polynomial 1 + 2z⁻¹ + z⁻². This means the feed-forward path needs only adds and a shift. Only the two feedback taps of each section use multipliers.

The per-section normalising gains are not applied. Instead, an arithmetic right shift between the two sections and a drop of low bits at the output set the overall DC gain. That gain stays large, roughly 1200 for one filter type and 2048 for the other. Two coefficient sets are built in, and a type request input selects between them. The active type is reported back on an output. Switching type clears all filter history, so that no transient mixes the two coefficient sets.

Top module: `bq_lowpass4`

## Requirements
- R1: After reset, `out_valid_o` is 0, `out_data_o` is 0 and `type_o` reads 1. All filter history is zero.
- R2: Each sample accepted with `in_valid_i` high produces one `out_valid_o` pulse exactly three clock edges later. Back-to-back samples give back-to-back outputs.
- R3: Each section computes y = x + 2·x₋₁ + x₋₂ − floor((b1·y₋₁ + b2·y₋₂) / 2¹⁴). The output is bit-exact with this equation for an impulse input.
- R4: Coefficients are stored as a sign bit plus a 15-bit magnitude with 14 fractional bits. Every b1 is negative and every b2 is positive. The magnitudes (section 1 b1, b2; section 2 b1, b2) are:
  - Type 1: 32092, 15751; 31238, 14896.
  - Type 2: 32295, 15915; 32568, 16188.
- R5: The second section's input is the first section's output arithmetically shifted right by 11 (type 1) or 14 (type 2). The final result is shifted right by 0 (type 1) or 3 (type 2).
- R6: The output saturates to the signed range of `out_data_o` (default 24 bits: +8388607 / −8388608) and never wraps.
- R7: A type request of 1 or 2 becomes active on the next edge. Request values 0 and 3 are ignored: `type_o` and the filter history are unchanged.
- R8: When a legal request differs from the active type, all history and all in-flight samples are cleared. A sample presented in that same cycle is discarded and produces no output.
- R9: Filter state advances only on accepted samples. Idle gaps between samples do not change the results.
- R10: For a settled step of 1000, the output lies between 1,150,000 and 1,300,000 for type 1, and between 2,000,000 and 2,100,000 for type 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| type_req_i | input | 2 | Requested coefficient set (1 or 2) |
| type_o | output | 2 | Active coefficient set |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | IN_W (16) | Signed input sample |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | OUT_W (24) | Signed, saturated filtered sample |

## Verification
A type change and a sample arrival can fall in the same cycle. Samples can also still be in flight inside the sections when the type changes. The bench provokes both cases. In one, it raises the input strobe on the very cycle a new type is requested. In the other, it requests a new type one cycle after a sample enters. In each case it is judged by the absence of any output strobe in the following cycles, and by an impulse afterwards that must match a model started from zero history.

// File: rtl/bq_lp_pkg.sv
`timescale 1ns/1ps
package bq_lp_pkg;
  localparam int COEF_W = 15;
  localparam int FRAC_W = 14;

  typedef logic [1:0] ftype_t;
  localparam ftype_t FT_A = 2'd1;
  localparam ftype_t FT_B = 2'd2;

  typedef struct packed {
    logic              neg;
    logic [COEF_W-1:0] mag;
  } coef_t;

  // sec: section index, tap: 0 -> first feedback tap, 1 -> second
  function automatic coef_t coef_lookup(ftype_t t, int sec, logic tap);
    coef_t c;
    c.neg = ~tap;
    if (t == FT_B) begin
      if (sec == 0) c.mag = tap ? 15'd15915 : 15'd32295;
      else          c.mag = tap ? 15'd16188 : 15'd32568;
    end else begin
      if (sec == 0) c.mag = tap ? 15'd15751 : 15'd32092;
      else          c.mag = tap ? 15'd14896 : 15'd31238;
    end
    return c;
  endfunction

  function automatic logic [3:0] mid_shift(ftype_t t);
    return (t == FT_B) ? 4'd14 : 4'd11;
  endfunction

  function automatic logic [3:0] out_drop(ftype_t t);
    return (t == FT_B) ? 4'd3 : 4'd0;
  endfunction
endpackage

// File: rtl/bq_section.sv
`timescale 1ns/1ps
module bq_section
  import bq_lp_pkg::*;
#(
  parameter int STATE_W = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      en_i,
  input  logic signed [STATE_W-1:0] x_i,
  input  coef_t                     b1_i,
  input  coef_t                     b2_i,
  output logic signed [STATE_W-1:0] y_o,
  output logic                      vld_o
);
  localparam int PW = STATE_W + COEF_W + 2;

  logic signed [STATE_W-1:0] x1_q, x2_q, y1_q, y2_q;
  logic signed [STATE_W-1:0] x1_n, x2_n, y1_n, y2_n;
  logic                      vld_q, vld_n;
  logic signed [COEF_W:0]    b1s, b2s;
  logic signed [PW-1:0]      prod, fb;
  logic signed [STATE_W-1:0] ff, y_calc;

  always_comb begin
    b1s    = b1_i.neg ? -$signed({1'b0, b1_i.mag}) : $signed({1'b0, b1_i.mag});
    b2s    = b2_i.neg ? -$signed({1'b0, b2_i.mag}) : $signed({1'b0, b2_i.mag});
    ff     = x_i + (x1_q <<< 1) + x2_q;
    prod   = PW'(b1s) * PW'(y1_q) + PW'(b2s) * PW'(y2_q);
    fb     = prod >>> FRAC_W;
    y_calc = ff - STATE_W'(fb);
  end

  always_comb begin
    x1_n  = x1_q;
    x2_n  = x2_q;
    y1_n  = y1_q;
    y2_n  = y2_q;
    vld_n = 1'b0;
    if (clr_i) begin
      x1_n = '0;
      x2_n = '0;
      y1_n = '0;
      y2_n = '0;
    end else if (en_i) begin
      x2_n  = x1_q;
      x1_n  = x_i;
      y2_n  = y1_q;
      y1_n  = y_calc;
      vld_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q  <= '0;
      x2_q  <= '0;
      y1_q  <= '0;
      y2_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      x1_q  <= x1_n;
      x2_q  <= x2_n;
      y1_q  <= y1_n;
      y2_q  <= y2_n;
      vld_q <= vld_n;
    end
  end

  assign y_o   = y1_q;
  assign vld_o = vld_q;

  // R9: history frozen between accepted samples
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> ($stable(y1_q) && $stable(x1_q) && $stable(y2_q)));
  // R8: a clear empties history and kills the strobe
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!vld_o && y1_q == '0 && x1_q == '0));
endmodule

// File: rtl/bq_outsat.sv
`timescale 1ns/1ps
module bq_outsat #(
  parameter int STATE_W = 40,
  parameter int OUT_W   = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      en_i,
  input  logic [3:0]                drop_i,
  input  logic signed [STATE_W-1:0] y_i,
  output logic signed [OUT_W-1:0]   data_o,
  output logic                      vld_o
);
  localparam logic signed [STATE_W-1:0] MAXV =
    {{(STATE_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [STATE_W-1:0] MINV =
    {{(STATE_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [STATE_W-1:0] shifted;
  logic signed [OUT_W-1:0]   data_q, data_n;
  logic                      vld_q, vld_n;

  always_comb begin
    shifted = y_i >>> drop_i;
    data_n  = data_q;
    vld_n   = 1'b0;
    if (en_i && !clr_i) begin
      vld_n = 1'b1;
      if (shifted > MAXV)      data_n = OUT_W'(MAXV);
      else if (shifted < MINV) data_n = OUT_W'(MINV);
      else                     data_n = OUT_W'(shifted);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      vld_q  <= vld_n;
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;

  // R6: out-of-range results clamp to the rails
  a_r6_clamp_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && shifted > MAXV) |=> (data_o == OUT_W'(MAXV)));
  a_r6_clamp_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && shifted < MINV) |=> (data_o == OUT_W'(MINV)));
endmodule

// File: rtl/bq_lowpass4.sv
`timescale 1ns/1ps
module bq_lowpass4
  import bq_lp_pkg::*;
#(
  parameter int          IN_W       = 16,
  parameter int          OUT_W      = 24,
  parameter int          STATE_W    = 40,
  parameter logic [1:0]  RESET_TYPE = 2'd1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              type_req_i,
  output logic [1:0]              type_o,
  input  logic                    in_valid_i,
  input  logic signed [IN_W-1:0]  in_data_i,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] out_data_o
);
  localparam int NSEC = 2;

  ftype_t type_q, type_n;
  logic   flush;

  always_comb begin
    flush  = ((type_req_i == FT_A) || (type_req_i == FT_B)) && (type_req_i != type_q);
    type_n = flush ? type_req_i : type_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) type_q <= RESET_TYPE;
    else        type_q <= type_n;
  end

  assign type_o = type_q;

  logic signed [STATE_W-1:0] sec_x [NSEC];
  logic signed [STATE_W-1:0] sec_y [NSEC];
  logic [NSEC-1:0]           sec_en;
  logic [NSEC-1:0]           sec_v;

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    if (g == 0) begin : g_head
      assign sec_x[g]  = STATE_W'(in_data_i);
      assign sec_en[g] = in_valid_i & ~flush;
    end else begin : g_link
      assign sec_x[g]  = sec_y[g-1] >>> mid_shift(type_q);
      assign sec_en[g] = sec_v[g-1] & ~flush;
    end

    bq_section #(.STATE_W(STATE_W)) u_sec (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (flush),
      .en_i  (sec_en[g]),
      .x_i   (sec_x[g]),
      .b1_i  (coef_lookup(type_q, g, 1'b0)),
      .b2_i  (coef_lookup(type_q, g, 1'b1)),
      .y_o   (sec_y[g]),
      .vld_o (sec_v[g])
    );
  end

  bq_outsat #(.STATE_W(STATE_W), .OUT_W(OUT_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (flush),
    .en_i   (sec_v[NSEC-1]),
    .drop_i (out_drop(type_q)),
    .y_i    (sec_y[NSEC-1]),
    .data_o (out_data_o),
    .vld_o  (out_valid_o)
  );

  // R2: every output strobe traces back to a sample three edges earlier
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $past(in_valid_i, 3));
  // R7: the active type is always a legal set
  a_r7_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (type_o == FT_A) || (type_o == FT_B));
  // R7: an illegal request leaves the active type alone
  a_r7_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    ((type_req_i == 2'd0) || (type_req_i == 2'd3)) |=> $stable(type_o));
  // R8: a type change drains the pipeline
  a_r8_drop_next: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid_o);
  a_r8_drop_later: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ##2 !out_valid_o);
endmodule

// File: tb/tb_bq_lowpass4.sv
`timescale 1ns/1ps
module tb_bq_lowpass4;
  localparam int  OUT_W = 24;
  localparam longint OMAX = 8388607;
  localparam longint OMIN = -8388608;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [1:0]         type_req;
  logic [1:0]         type_o;
  logic               in_valid;
  logic signed [15:0] in_data;
  logic               out_valid;
  logic signed [OUT_W-1:0] out_data;

  always #10 clk = ~clk;

  bq_lowpass4 dut (
    .clk(clk), .rst_n(rst_n), .type_req_i(type_req), .type_o(type_o),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  int     checks = 0;
  int     bad    = 0;
  string  cur_req = "R1";
  longint expq[$];
  longint last_out = 0;

  // independent reference model
  int     mtype = 1;
  longint mx1[2], mx2[2], my1[2], my2[2];

  function automatic void mreset();
    for (int s = 0; s < 2; s++) begin
      mx1[s] = 0; mx2[s] = 0; my1[s] = 0; my2[s] = 0;
    end
  endfunction

  function automatic longint coef(int s, int tap);
    if (mtype == 2) begin
      if (s == 0) return tap == 0 ? -32295 : 15915;
      else        return tap == 0 ? -32568 : 16188;
    end
    if (s == 0) return tap == 0 ? -32092 : 15751;
    return tap == 0 ? -31238 : 14896;
  endfunction

  function automatic longint sec_step(int s, longint x);
    longint ff, fb, y;
    ff = x + 2 * mx1[s] + mx2[s];
    fb = (coef(s, 0) * my1[s] + coef(s, 1) * my2[s]) >>> 14;
    y  = ff - fb;
    mx2[s] = mx1[s]; mx1[s] = x;
    my2[s] = my1[s]; my1[s] = y;
    return y;
  endfunction

  function automatic longint model(longint x);
    longint a, b, o;
    a = sec_step(0, x);
    b = sec_step(1, a >>> (mtype == 2 ? 14 : 11));
    o = b >>> (mtype == 2 ? 3 : 0);
    if (o > OMAX) o = OMAX;
    if (o < OMIN) o = OMIN;
    return o;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // output monitor: compares every strobe against the model queue
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      last_out = out_data;
      if (expq.size() == 0) begin
        checks++; bad++;
        $display("FAIL %s unexpected output actual=%0d expected=none", cur_req, out_data);
      end else begin
        longint e;
        e = expq.pop_front();
        chk(out_data == e, cur_req, out_data, e);
      end
    end
  end

  task automatic send(longint x, int gap);
    in_valid = 1'b1;
    in_data  = 16'(x);
    expq.push_back(model(x));
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, cur_req, expq.size(), 0);
  endtask

  task automatic set_type(int t);
    type_req = 2'(t);
    @(negedge clk);
    if ((t == 1 || t == 2) && t != mtype) begin
      mreset();
      mtype = t;
    end
    chk(type_o == 2'(mtype), cur_req, type_o, mtype);
  endtask

  task automatic t_reset();
    cur_req = "R1";
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(out_data == '0, "R1", out_data, 0);
    chk(type_o == 2'd1, "R1", type_o, 1);
  endtask

  task automatic t_latency();
    cur_req = "R2";
    in_valid = 1'b1; in_data = 16'sd100;
    expq.push_back(model(100));
    @(negedge clk); in_valid = 1'b0;
    chk(!out_valid, "R2 edge1", out_valid, 0);
    @(negedge clk);
    chk(!out_valid, "R2 edge2", out_valid, 0);
    @(negedge clk);
    chk(out_valid, "R2 edge3", out_valid, 1);
    @(negedge clk);
    chk(!out_valid, "R2 edge4", out_valid, 0);
    for (int i = 0; i < 8; i++) send(0, 0);   // back-to-back samples
    drain();
  endtask

  task automatic t_impulse();
    cur_req = "R3";
    send(1000, 0);
    for (int i = 0; i < 80; i++) send(0, 0);
    drain();
  endtask

  task automatic t_ignore();
    cur_req = "R7";
    send(2000, 0);
    send(0, 0);
    set_type(0);
    send(0, 0);
    set_type(3);
    for (int i = 0; i < 20; i++) send(0, 0);
    set_type(mtype);
    drain();
  endtask

  task automatic t_step_gain(int t, longint lo, longint hi, string req);
    cur_req = req;
    for (int i = 0; i < 2500; i++) send(1000, 0);
    drain();
    chk(last_out >= lo && last_out <= hi, req, last_out, lo);
    chk(type_o == 2'(t), req, type_o, t);
  endtask

  task automatic t_flush();
    cur_req = "R8";
    // sample coincident with the type change is discarded
    type_req = 2'd2; in_valid = 1'b1; in_data = 16'sd700;
    @(negedge clk); in_valid = 1'b0;
    mreset(); mtype = 2;
    chk(type_o == 2'd2, "R8", type_o, 2);
    drain();
    // sample in flight when the type changes is discarded
    in_valid = 1'b1; in_data = 16'sd900;
    @(negedge clk); in_valid = 1'b0;
    type_req = 2'd1;
    @(negedge clk);
    mreset(); mtype = 1;
    chk(type_o == 2'd1, "R8", type_o, 1);
    drain();
    // fresh history: an impulse must match a model started from zero
    send(1500, 0);
    for (int i = 0; i < 30; i++) send(0, 0);
    drain();
    set_type(2);
    drain();
  endtask

  task automatic t_saturate();
    cur_req = "R6";
    for (int i = 0; i < 2500; i++) send(30000, 0);
    drain();
    chk(last_out == OMAX, "R6 high", last_out, OMAX);
    for (int i = 0; i < 2500; i++) send(-30000, 0);
    drain();
    chk(last_out == OMIN, "R6 low", last_out, OMIN);
  endtask

  task automatic t_gaps();
    cur_req = "R9";
    for (int i = 0; i < 300; i++)
      send(longint'($signed(16'($urandom))) >>> 2, int'($urandom_range(0, 3)));
    drain();
  endtask

  task automatic t_random_t1();
    cur_req = "R5";
    set_type(1);
    for (int i = 0; i < 300; i++)
      send(longint'($signed(16'($urandom))), 0);
    drain();
    cur_req = "R4";
    set_type(2);
    for (int i = 0; i < 300; i++)
      send(longint'($signed(16'($urandom))) >>> 4, 0);
    drain();
  endtask

  initial begin
    #(200000 * 20);
    checks++; bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; type_req = 2'd1; in_valid = 1'b0; in_data = '0;
    mreset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_impulse();
    t_ignore();
    t_step_gain(1, 1150000, 1300000, "R10 type1");
    t_flush();
    mreset();
    set_type(1);
    set_type(2);
    t_step_gain(2, 2000000, 2100000, "R10 type2");
    t_saturate();
    t_gaps();
    t_random_t1();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule